// File: doc/BRIEF.md
# AC-link Frame Serializer and Deserializer

This block is the framing engine on the controller side of an AC-link. It runs entirely on the bit clock that the codec supplies and produces the frame marker SYNC itself. Every frame lasts 256 bit clocks and carries a 16-bit tag slot followed by twelve 20-bit data slots. The block serializes one outgoing frame on `sdata_o` and collects one incoming frame from `sdata_i` in the same period.

Outgoing words come from a parallel holding input (`tag_i` plus `slots_i`). The block captures these once per frame, at the rising edge that launches the first tag bit, so upstream logic may rewrite them at any time. Received words appear in parallel on `rx_tag_o` and `rx_slots_o` together with a one-cycle `frame_done_o` strobe. Command semantics, sample formatting and the crossing into a system clock belong to neighbouring blocks.

Top module: `ac_link_framer`

## Requirements
- R1: While `rst_ni` is low, `sync_o`, `sdata_o` and `frame_done_o` are 0, and `rx_tag_o` and `rx_slots_o` are all zeros.
- R2: Successive rising edges of `sync_o` are exactly 256 bit clocks apart. The first one occurs on the first rising clock edge after reset is released.
- R3: `sync_o` stays high for exactly 16 consecutive bit clocks. It rises one bit clock before the first tag bit appears on `sdata_o`.
- R4: Outputs change on the rising clock edge, most significant bit first. The tag (bit 15 first) is followed by slots 1 to 12 in order. Slot n is taken from `slots_i[(12-n)*20 +: 20]`, so the transmitted frame equals the 256-bit vector {tag, slots} sent from its top bit down.
- R5: Tag bits 2:0 always go out as 0, whatever `tag_i[2:0]` holds. Bits 15:3 pass through unchanged.
- R6: The holding inputs are captured only at the rising edge that launches tag bit 15. Changes made at any other time during a frame appear only in the next frame.
- R7: `sdata_i` is sampled on the falling clock edge. The 256 bits of one frame are presented as `rx_tag_o` (first 16 bits received) and `rx_slots_o` (the next 240 bits, with the same slot layout as `slots_i`).
- R8: `frame_done_o` is high for exactly one bit clock. It begins at the rising edge right after the last bit of slot 12 is sampled, which is also the edge that launches the next tag bit 15. The receive outputs update on that edge and stay unchanged until the next strobe.
- R9: No strobe is issued at the first frame start after reset, because no complete frame has yet been received. The first strobe comes one full frame later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock supplied by the codec |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_i | input | 16 | Tag slot to transmit (ready bit 15, slot valid flags 14:3) |
| slots_i | input | 240 | Data slots 1 to 12 to transmit, slot 1 in the top 20 bits |
| sdata_i | input | 1 | Serial data from the codec |
| sync_o | output | 1 | Frame marker, active high |
| sdata_o | output | 1 | Serial data to the codec |
| rx_tag_o | output | 16 | Received tag slot |
| rx_slots_o | output | 240 | Received slots 1 to 12, slot 1 in the top 20 bits |
| frame_done_o | output | 1 | One-cycle strobe when a received frame is presented |

## Verification
The assertions assume a free-running bit clock, and they assume `sdata_i` changes only near the rising edge so that it is settled when the falling edge samples it. They take nothing for granted about when the holding inputs change, because capture at the frame start is exactly what R6 checks. The stimulus follows the codec convention: it drives `sdata_i` and the holding inputs one nanosecond after each rising edge. It rewrites the holding words both at frame starts and in the middle of frames, so any leak of a mid-frame change into the current frame would show up as a mismatch.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;
  localparam int unsigned TAG_BITS_DEF  = 16;
  localparam int unsigned SLOT_BITS_DEF = 20;
  localparam int unsigned DSLOTS_DEF    = 12;
endpackage

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer #(
  parameter int unsigned FRAME_W = 256,
  parameter int unsigned SYNC_W  = 16,
  localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             sync_o,
  output logic             frame_start_o,
  output logic             capture_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q, sync_d;
  logic             primed_q;

  assign cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
  // sync covers the last bit of the previous frame plus the first SYNC_W-1 bits
  assign sync_d = (cnt_d == LAST) || (cnt_d < CNT_W'(SYNC_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_W'(FRAME_W - 2);
      sync_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
      if (frame_start_o) primed_q <= 1'b1;
    end
  end

  assign bit_idx_o     = cnt_q;
  assign sync_o        = sync_q;
  assign frame_start_o = (cnt_d == '0);
  assign capture_o     = frame_start_o && primed_q;

  // checker counters
  logic [CNT_W:0] per_q, hi_q;
  logic           prev_sync_q, rose_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q       <= '0;
      hi_q        <= '0;
      prev_sync_q <= 1'b0;
      rose_seen_q <= 1'b0;
    end else begin
      prev_sync_q <= sync_q;
      if (sync_q && !prev_sync_q) begin
        per_q       <= '0;
        rose_seen_q <= 1'b1;
      end else if (per_q != '1) begin
        per_q <= per_q + (CNT_W+1)'(1);
      end
      if (sync_q) begin
        if (hi_q != '1) hi_q <= hi_q + (CNT_W+1)'(1);
      end else begin
        hi_q <= '0;
      end
    end
  end

  p_sync_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && !prev_sync_q && rose_seen_q) |-> (per_q == (CNT_W+1)'(FRAME_W - 1)));

  p_sync_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> (hi_q == (CNT_W+1)'(SYNC_W)));

  p_sync_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |=> (bit_idx_o == '0));
endmodule

// File: rtl/aclk_tx_shifter.sv
module aclk_tx_shifter #(
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned DATA_W = 240,
  parameter int unsigned ZERO_W = 3,
  localparam int unsigned FRAME_W = TAG_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdata_o
);
  localparam logic [TAG_W-1:0] TAG_KEEP = ~TAG_W'((64'd1 << ZERO_W) - 64'd1);

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] load_val;

  assign load_val = {tag_i & TAG_KEEP, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= load_val;
    else             sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign sdata_o = sh_q[FRAME_W-1];

  p_load_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sdata_o == $past(tag_i[TAG_W-1])));
endmodule

// File: rtl/aclk_rx_shifter.sv
module aclk_rx_shifter #(
  parameter int unsigned FRAME_W = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sdata_i,
  input  logic               capture_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);
  logic [FRAME_W-1:0] sh_q, frame_q;
  logic               done_q, run_q;

  // inputs are sampled on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[FRAME_W-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      done_q  <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      run_q  <= 1'b1;
      done_q <= capture_i;
      if (capture_i) frame_q <= sh_q;
    end
  end

  assign frame_o = frame_q;
  assign done_o  = done_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !done_o) |-> $stable(frame_o));
endmodule

// File: rtl/ac_link_framer.sv
module ac_link_framer #(
  parameter int unsigned TAG_W     = ac_link_pkg::TAG_BITS_DEF,
  parameter int unsigned SLOT_W    = ac_link_pkg::SLOT_BITS_DEF,
  parameter int unsigned NUM_SLOTS = ac_link_pkg::DSLOTS_DEF,
  localparam int unsigned DATA_W   = SLOT_W * NUM_SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] slots_i,
  input  logic              sdata_i,
  output logic              sync_o,
  output logic              sdata_o,
  output logic [TAG_W-1:0]  rx_tag_o,
  output logic [DATA_W-1:0] rx_slots_o,
  output logic              frame_done_o
);
  localparam int unsigned FRAME_W = TAG_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam int unsigned ZERO_W  = TAG_W - 1 - NUM_SLOTS;

  logic [CNT_W-1:0]   bit_idx;
  logic               frame_start, capture;
  logic [FRAME_W-1:0] rx_frame;

  aclk_frame_timer #(.FRAME_W(FRAME_W), .SYNC_W(TAG_W)) u_timer (
    .clk_i, .rst_ni,
    .bit_idx_o(bit_idx), .sync_o,
    .frame_start_o(frame_start), .capture_o(capture)
  );

  aclk_tx_shifter #(.TAG_W(TAG_W), .DATA_W(DATA_W), .ZERO_W(ZERO_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i(frame_start), .tag_i, .data_i(slots_i), .sdata_o
  );

  aclk_rx_shifter #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i, .rst_ni, .sdata_i,
    .capture_i(capture), .frame_o(rx_frame), .done_o(frame_done_o)
  );

  assign rx_tag_o   = rx_frame[FRAME_W-1 -: TAG_W];
  assign rx_slots_o = rx_frame[DATA_W-1:0];

  p_tag_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bit_idx >= CNT_W'(TAG_W - ZERO_W)) && (bit_idx < CNT_W'(TAG_W))) |-> !sdata_o);

  p_done_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (bit_idx == '0));
endmodule

// File: tb/tb_ac_link_framer.sv
`timescale 1ns/100ps
module tb_ac_link_framer;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  tag_i;
  logic [239:0] slots_i;
  logic         sdata_i;
  logic         sync_o, sdata_o, frame_done_o;
  logic [15:0]  rx_tag_o;
  logic [239:0] rx_slots_o;

  ac_link_framer dut (
    .clk_i, .rst_ni, .tag_i, .slots_i, .sdata_i,
    .sync_o, .sdata_o, .rx_tag_o, .rx_slots_o, .frame_done_o
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd_frame();
    logic [255:0] r = '0;
    for (int i = 0; i < 8; i++) r = {r[223:0], $urandom()};
    return r;
  endfunction

  function automatic logic [255:0] pat(input int k);
    case (k)
      0: return '1;
      1: return '0;
      2: return {128{2'b10}};
      default: return rnd_frame();
    endcase
  endfunction

  function automatic logic [255:0] tx_expect(input logic [15:0] t, input logic [239:0] s);
    return {t[15:3], 3'b000, s};
  endfunction

  // monitor state
  bit           seen = 1'b0;
  int           pos = 0, gap = 0, hi = 0, rises = 0, frames = 0;
  logic         psync = 1'b0;
  logic [255:0] txcap = '0, exp_tx = '0;
  bit           exp_ok = 1'b0;
  // codec model state
  int           started = 0, hold_k = 1;
  logic [255:0] cdx_cur = '0, cdx_prev = '0;

  // codec and holding-register driver, 1 ns after each rising edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      int nxt;
      #1;
      nxt = seen ? (pos + 1) % 256 : -1;
      if (nxt == 0) begin
        cdx_prev = cdx_cur;
        cdx_cur  = pat(started);
        started++;
        {tag_i, slots_i} = pat(hold_k);
        hold_k++;
      end
      if (nxt == 128 && ($urandom() % 2 == 0)) {tag_i, slots_i} = rnd_frame();
      sdata_i = (nxt >= 0) ? cdx_cur[255 - nxt] : 1'b0;
    end
  end

  // monitor on falling edges
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (sync_o && !psync) begin
        if (rises > 0) chk(gap == 255, "R2 sync period", gap + 1, 256);
        rises++;
        gap  = 0;
        pos  = 255;
        seen = 1'b1;
      end else begin
        gap++;
        if (seen) pos = (pos + 1) % 256;
      end
      if (sync_o) hi++;
      else begin
        if (psync) chk(hi == 16, "R3 sync width", hi, 16);
        hi = 0;
      end
      if (seen) begin
        txcap[255 - pos] = sdata_o;
        if (pos == 15) chk(txcap[242:240] == 3'b000, "R5 tag low bits", txcap[242:240], 0);
        if (pos == 255) begin
          if (exp_ok) chk(txcap == exp_tx, "R4 R6 tx frame", txcap, exp_tx);
          exp_tx = tx_expect(tag_i, slots_i);
          exp_ok = 1'b1;
        end
        if (pos == 0) begin
          chk(frame_done_o == (started >= 2), "R8 R9 strobe", frame_done_o, started >= 2);
          if (frame_done_o) chk({rx_tag_o, rx_slots_o} == cdx_prev, "R7 rx frame", {rx_tag_o, rx_slots_o}, cdx_prev);
          frames++;
        end else begin
          if (frame_done_o) chk(1'b0, "R8 stray strobe", pos, 0);
          if (pos == 128 && started >= 2)
            chk({rx_tag_o, rx_slots_o} == cdx_prev, "R8 rx hold", {rx_tag_o, rx_slots_o}, cdx_prev);
        end
      end
      psync = sync_o;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd20251);
    {tag_i, slots_i} = '1;
    sdata_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(sync_o == 1'b0, "R1 sync", sync_o, 0);
    chk(sdata_o == 1'b0, "R1 sdata", sdata_o, 0);
    chk(frame_done_o == 1'b0, "R1 strobe", frame_done_o, 0);
    chk({rx_tag_o, rx_slots_o} == '0, "R1 rx", {rx_tag_o, rx_slots_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #0.1;
    chk(sync_o == 1'b1, "R2 first sync", sync_o, 1);
    wait (frames >= 14);
    @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule